// File: doc/BRIEF.md
# USB Host Interrupt Aggregation Tree

This block collects interrupt status for a multi-channel USB host controller and reduces it to one level-sensitive interrupt line for the CPU. Each host channel owns a status register, set by one-cycle event pulses from its channel engine, and a mask register of the same layout. A pending-channels register shows which channels hold an unmasked status bit. An all-channels mask then selects which channels feed a single channel summary bit in the core interrupt register. That register also carries start-of-frame, disconnect and a port-change summary. A core mask and a global enable bit gate the final output.

Software reaches every register through a simple word-addressed port: a write strobe with address and data, and a combinational read data bus. The port-change and channel summary bits in the core register are read-only mirrors. Writing to the core register leaves them unchanged. They clear only when their source registers are cleared.

Top module: `usb_irq_tree`

## Requirements
- R1: After reset, every status, mask and enable register reads zero and `irq_o` is low.
- R2: `irq_o` can be high only while bit 0 of the config register (word address 0x00) is set; with that bit clear, no source raises `irq_o`.
- R3: Channel status (word address 0x20 + channel) holds 14 event bits, set by the matching bit of the channel's event pulse: 0 transfer done, 1 halted, 2 bus error, 3 STALL, 4 NAK, 5 ACK, 6 NYET, 7 transaction error, 8 babble, 9 frame overrun, 10 toggle error, 11 buffer unavailable, 12 excess transaction, 13 frame list rollover. Bits 31..14 read as zero.
- R4: Writing 1 to a channel status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: The channel mask (word address 0x30 + channel) uses the status layout, where 1 enables a bit. Only bits 13..0 are stored. A channel is pending only when a status bit and its mask bit are both set.
- R6: The pending-channels register (0x04, read-only) has bit i set when channel i is pending. Core bit 25 is set when a pending channel also has its bit set in the all-channels mask (0x05).
- R7: The core register (0x01) shows start-of-frame on bit 3, port change on bit 24, channel summary on bit 25 and disconnect on bit 29. Bits 3 and 29 are set by event pulses and cleared by writing 1.
- R8: Writes to the core register never clear bits 24 or 25. Bit 24 clears only when bit 0 of the port status register (0x03) is cleared by writing 1, and bit 25 clears only when the channel status is cleared.
- R9: The core mask (0x02) uses the same bit positions as the core register. A core bit whose mask bit is clear does not raise `irq_o`.
- R10: `irq_o` is registered. It rises on the clock edge after an enabled source becomes set, and it falls on the clock edge after the last enabled source is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ch_evt_i | input | NUM_CH*14 | Per-channel event pulses, channel i at bits [14i+13:14i] |
| sof_evt_i | input | 1 | Start-of-frame event pulse |
| port_evt_i | input | 1 | Host port change event pulse |
| disc_evt_i | input | 1 | Device disconnect event pulse |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The assertions check several rules on every cycle: an event pulse always leaves its status bit set, a write-1 with no event clears the channel status, a core write never drops the port summary, a pending channel always has a nonzero status, and the interrupt never rises without the global enable. Other behaviour is shown only by the bench scenarios: the register layout, reserved bits reading zero, the one-cycle latency of the output on both edges, and how the four enable levels combine. The bench drives each case directly and reads the results back through the port.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned ADDR_W     = 6;
   localparam int unsigned CH_STAT_W  = 14;
   localparam int unsigned MAX_CH     = 16;

   // core register bit positions
   localparam int unsigned CORE_SOF_BIT  = 3;
   localparam int unsigned CORE_PORT_BIT = 24;
   localparam int unsigned CORE_CHAN_BIT = 25;
   localparam int unsigned CORE_DISC_BIT = 29;

   // word addresses
   localparam logic [ADDR_W-1:0] A_CFG   = 6'h00;
   localparam logic [ADDR_W-1:0] A_CORE  = 6'h01;
   localparam logic [ADDR_W-1:0] A_CMASK = 6'h02;
   localparam logic [ADDR_W-1:0] A_PORT  = 6'h03;
   localparam logic [ADDR_W-1:0] A_PEND  = 6'h04;
   localparam logic [ADDR_W-1:0] A_AMASK = 6'h05;
   localparam logic [1:0]        R_STAT  = 2'b10;  // 0x20..0x2F
   localparam logic [1:0]        R_MASK  = 2'b11;  // 0x30..0x3F

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_STAT = 2'd1,
      SRC_MASK = 2'd2
   } ch_access_e;
endpackage

// File: rtl/usb_irq_chan_slice.sv
module usb_irq_chan_slice #(
   parameter int unsigned SW = 14
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [SW-1:0] evt_i,
   input  logic          stat_wr_i,
   input  logic          mask_wr_i,
   input  logic [SW-1:0] wdata_i,
   output logic [SW-1:0] stat_o,
   output logic [SW-1:0] mask_o,
   output logic          pend_o
);
   logic [SW-1:0] stat_q, mask_q, clr_v;

   assign clr_v = stat_wr_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_v) | evt_i;
         if (mask_wr_i) mask_q <= wdata_i;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign pend_o = |(stat_q & mask_q);

   AST_EVT_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4
   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr_i && wdata_i == '1 && evt_i == '0) |=> (stat_q == '0)); // R4
endmodule

// File: rtl/usb_irq_core_unit.sv
module usb_irq_core_unit
   import usb_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sof_evt_i,
   input  logic              port_evt_i,
   input  logic              disc_evt_i,
   input  logic              cfg_wr_i,
   input  logic              core_wr_i,
   input  logic              cmask_wr_i,
   input  logic              port_wr_i,
   input  logic              amask_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NUM_CH-1:0] chan_pend_i,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] core_o,
   output logic [DATA_W-1:0] cmask_o,
   output logic [DATA_W-1:0] port_o,
   output logic [DATA_W-1:0] amask_o,
   output logic              irq_o
);
   logic              gen_q, sof_q, disc_q, port_q, irq_q;
   logic [3:0]        cmask_q;     // {disc, chan, port, sof}
   logic [NUM_CH-1:0] amask_q;
   logic              chan_sum;
   logic [3:0]        src_v;
   logic              unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign chan_sum     = |(chan_pend_i & amask_q);
   assign src_v        = {disc_q, chan_sum, port_q, sof_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gen_q   <= 1'b0;
         sof_q   <= 1'b0;
         disc_q  <= 1'b0;
         port_q  <= 1'b0;
         cmask_q <= '0;
         amask_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         sof_q  <= sof_evt_i  | (sof_q  & ~(core_wr_i & wdata_i[CORE_SOF_BIT]));
         disc_q <= disc_evt_i | (disc_q & ~(core_wr_i & wdata_i[CORE_DISC_BIT]));
         port_q <= port_evt_i | (port_q & ~(port_wr_i & wdata_i[0]));
         if (cfg_wr_i)   gen_q   <= wdata_i[0];
         if (cmask_wr_i) cmask_q <= {wdata_i[CORE_DISC_BIT], wdata_i[CORE_CHAN_BIT],
                                     wdata_i[CORE_PORT_BIT], wdata_i[CORE_SOF_BIT]};
         if (amask_wr_i) amask_q <= wdata_i[NUM_CH-1:0];
         irq_q <= gen_q & |(src_v & cmask_q);
      end
   end

   always_comb begin
      cfg_o   = '0;
      cfg_o[0] = gen_q;
      core_o  = '0;
      core_o[CORE_SOF_BIT]  = sof_q;
      core_o[CORE_PORT_BIT] = port_q;
      core_o[CORE_CHAN_BIT] = chan_sum;
      core_o[CORE_DISC_BIT] = disc_q;
      cmask_o = '0;
      cmask_o[CORE_SOF_BIT]  = cmask_q[0];
      cmask_o[CORE_PORT_BIT] = cmask_q[1];
      cmask_o[CORE_CHAN_BIT] = cmask_q[2];
      cmask_o[CORE_DISC_BIT] = cmask_q[3];
      port_o  = '0;
      port_o[0] = port_q;
      amask_o = '0;
      amask_o[NUM_CH-1:0] = amask_q;
   end

   assign irq_o = irq_q;

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(gen_q)); // R2
   AST_PORT_SUMMARY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_wr_i && port_q && !port_wr_i) |=> port_q); // R8
   AST_SOF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sof_evt_i |=> sof_q); // R7
endmodule

// File: rtl/usb_irq_tree.sv
module usb_irq_tree
   import usb_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_en_i,
   input  logic [5:0]                  addr_i,
   input  logic [31:0]                 wdata_i,
   output logic [31:0]                 rdata_o,
   input  logic [NUM_CH*CH_STAT_W-1:0] ch_evt_i,
   input  logic                        sof_evt_i,
   input  logic                        port_evt_i,
   input  logic                        disc_evt_i,
   output logic                        irq_o
);
   localparam int unsigned SW = CH_STAT_W;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("usb_irq_tree: NUM_CH must lie in 1..16");
   end

   logic [SW-1:0]     stat_a [NUM_CH];
   logic [SW-1:0]     mask_a [NUM_CH];
   logic [NUM_CH-1:0] pend_v;
   logic [NUM_CH-1:0] stat_wr_v, mask_wr_v;
   logic [DATA_W-1:0] cfg_w, core_w, cmask_w, port_w, amask_w;
   ch_access_e        acc;

   always_comb begin
      unique case (addr_i[5:4])
         R_STAT:  acc = SRC_STAT;
         R_MASK:  acc = SRC_MASK;
         default: acc = SRC_NONE;
      endcase
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign stat_wr_v[i] = wr_en_i && acc == SRC_STAT && addr_i[3:0] == 4'(i);
      assign mask_wr_v[i] = wr_en_i && acc == SRC_MASK && addr_i[3:0] == 4'(i);

      usb_irq_chan_slice #(.SW(SW)) u_slice (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .evt_i     (ch_evt_i[i*SW +: SW]),
         .stat_wr_i (stat_wr_v[i]),
         .mask_wr_i (mask_wr_v[i]),
         .wdata_i   (wdata_i[SW-1:0]),
         .stat_o    (stat_a[i]),
         .mask_o    (mask_a[i]),
         .pend_o    (pend_v[i])
      );

      AST_PEND_HAS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pend_v[i] |-> (stat_a[i] != '0)); // R6
   end

   usb_irq_core_unit #(.NUM_CH(NUM_CH)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sof_evt_i   (sof_evt_i),
      .port_evt_i  (port_evt_i),
      .disc_evt_i  (disc_evt_i),
      .cfg_wr_i    (wr_en_i && addr_i == A_CFG),
      .core_wr_i   (wr_en_i && addr_i == A_CORE),
      .cmask_wr_i  (wr_en_i && addr_i == A_CMASK),
      .port_wr_i   (wr_en_i && addr_i == A_PORT),
      .amask_wr_i  (wr_en_i && addr_i == A_AMASK),
      .wdata_i     (wdata_i),
      .chan_pend_i (pend_v),
      .cfg_o       (cfg_w),
      .core_o      (core_w),
      .cmask_o     (cmask_w),
      .port_o      (port_w),
      .amask_o     (amask_w),
      .irq_o       (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      case (acc)
         SRC_STAT: begin
            for (int i = 0; i < NUM_CH; i++)
               if (addr_i[3:0] == 4'(i)) rdata_o[SW-1:0] = stat_a[i];
         end
         SRC_MASK: begin
            for (int i = 0; i < NUM_CH; i++)
               if (addr_i[3:0] == 4'(i)) rdata_o[SW-1:0] = mask_a[i];
         end
         default: begin
            case (addr_i)
               A_CFG:   rdata_o = cfg_w;
               A_CORE:  rdata_o = core_w;
               A_CMASK: rdata_o = cmask_w;
               A_PORT:  rdata_o = port_w;
               A_PEND:  rdata_o[NUM_CH-1:0] = pend_v;
               A_AMASK: rdata_o = amask_w;
               default: rdata_o = '0;
            endcase
         end
      endcase
   end
endmodule

// File: tb/usb_irq_tree_tb_top.sv
module usb_irq_tree_tb_top;
   localparam int NCH = 8;
   localparam int SW  = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [5:0]        addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [NCH*SW-1:0] ch_evt = '0;
   logic              sof_evt = 1'b0, port_evt = 1'b0, disc_evt = 1'b0;
   logic              irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;  // 125 MHz

   usb_irq_tree #(.NUM_CH(NCH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .ch_evt_i(ch_evt),
      .sof_evt_i(sof_evt), .port_evt_i(port_evt), .disc_evt_i(disc_evt),
      .irq_o(irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp);
   endtask

   task automatic ch_pulse(int ch, logic [SW-1:0] bits);
      @(negedge clk);
      ch_evt[ch*SW +: SW] = bits;
      @(negedge clk);
      ch_evt = '0;
   endtask

   task automatic t_reset();
      rd_check("R1 cfg", 6'h00, 0);
      rd_check("R1 core", 6'h01, 0);
      rd_check("R1 cmask", 6'h02, 0);
      rd_check("R1 ch0 stat", 6'h20, 0);
      rd_check("R1 ch3 mask", 6'h33, 0);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_channel_path();
      ch_pulse(2, 14'h0010);  // NAK on channel 2
      rd_check("R3 NAK bit4", 6'h22, 32'h10);
      rd_check("R5 unmasked not pending", 6'h04, 0);
      wr(6'h32, 32'h10);
      rd_check("R6 pending ch2", 6'h04, 32'h04);
      rd_check("R6 core25 needs amask", 6'h01, 0);
      wr(6'h05, 32'h04);
      rd_check("R6 core25 set", 6'h01, 32'h0200_0000);
      wr(6'h02, 32'h0200_0000);
      @(negedge clk);
      check("R2 no irq when disabled", {31'b0, irq}, 0);
      wr(6'h00, 32'h1);
      check("R10 irq one cycle later", {31'b0, irq}, 0);
      @(negedge clk);
      check("R10 irq rises", {31'b0, irq}, 1);
   endtask

   task automatic t_summary_and_clear();
      wr(6'h01, 32'hFFFF_FFFF);
      rd_check("R8 core25 survives core write", 6'h01, 32'h0200_0000);
      check("R8 irq stays", {31'b0, irq}, 1);
      wr(6'h22, 32'h10);
      rd_check("R4 w1c ch2", 6'h22, 0);
      check("R10 irq held one cycle", {31'b0, irq}, 1);
      @(negedge clk);
      check("R10 irq falls", {31'b0, irq}, 0);
      rd_check("R8 core25 cleared at source", 6'h01, 0);
   endtask

   task automatic t_set_wins();
      ch_pulse(2, 14'h0001);
      @(negedge clk);
      addr = 6'h22; wdata = 32'h1; wr_en = 1'b1; ch_evt[2*SW +: SW] = 14'h0001;
      @(negedge clk);
      wr_en = 1'b0; ch_evt = '0;
      rd_check("R4 set wins over clear", 6'h22, 32'h1);
      wr(6'h22, 32'h0);
      rd_check("R4 write 0 keeps", 6'h22, 32'h1);
      wr(6'h22, 32'h1);
      ch_pulse(1, 14'h3FFF);
      rd_check("R3 all bits, reserved zero", 6'h21, 32'h3FFF);
      wr(6'h31, 32'hFFFF_FFFF);
      rd_check("R5 mask reserved zero", 6'h31, 32'h3FFF);
      wr(6'h21, 32'hFFFF_FFFF);
      wr(6'h31, 32'h0);
      ch_pulse(0, 14'h0020);
      ch_pulse(5, 14'h2000);
      wr(6'h30, 32'h20);
      wr(6'h35, 32'h2000);
      rd_check("R6 pending ch0 ch5", 6'h04, 32'h21);
      wr(6'h20, 32'h20);
      wr(6'h25, 32'h2000);
   endtask

   task automatic t_core_sources();
      // core mask currently only bit25
      @(negedge clk); sof_evt = 1'b1; @(negedge clk); sof_evt = 1'b0;
      rd_check("R7 sof bit3", 6'h01, 32'h8);
      @(negedge clk);
      check("R9 masked sof no irq", {31'b0, irq}, 0);
      wr(6'h02, 32'h2300_0008);
      @(negedge clk);
      check("R9 sof enabled irq", {31'b0, irq}, 1);
      wr(6'h01, 32'h8);
      rd_check("R7 sof w1c", 6'h01, 0);
      @(negedge clk); disc_evt = 1'b1; @(negedge clk); disc_evt = 1'b0;
      rd_check("R7 disconnect bit29", 6'h01, 32'h2000_0000);
      wr(6'h01, 32'h2000_0000);
      @(negedge clk); port_evt = 1'b1; @(negedge clk); port_evt = 1'b0;
      rd_check("R7 port bit24", 6'h01, 32'h0100_0000);
      wr(6'h01, 32'h0100_0000);
      rd_check("R8 port bit24 survives", 6'h01, 32'h0100_0000);
      @(negedge clk);
      check("R9 port irq", {31'b0, irq}, 1);
      wr(6'h00, 32'h0);
      @(negedge clk);
      check("R2 disable drops irq", {31'b0, irq}, 0);
      wr(6'h03, 32'h1);
      rd_check("R8 port cleared at source", 6'h01, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_channel_path();
      t_summary_and_clear();
      t_set_wins();
      t_core_sources();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule